// File: doc/BRIEF.md
# Grouped system-management interrupt output

This block merges many interrupt requests into a single system-management interrupt line. The requests come from functional units and general-purpose pins. Each request has its own enable bit in a bank of five 8-bit enable registers. One bit of the second register is set aside as a master gate. A request reaches the line only when its enable bit is set and the master gate is open.

A pin control register sets how the merged signal appears at the pad. One bit picks the asserted level. Another bit picks the buffer style: open-drain or push-pull. The pad is modelled as a drive-enable and data pair, with the line assumed to be pulled high when released. The output is registered. After reset the line is active low and open-drain, and it is released while nothing is requesting.

Software reaches the six registers through a simple write strobe and a combinational read port.

Top module: `smi_group`

## Requirements
- R1: After reset all enable bits and pin control bits are 0, and the pad is released (`pin_oe`=0, `pin_do`=0).
- R2: Addresses 0 to 4 select enable registers 1 to 5. Address 5 selects the pin control register, where only bit 7 (buffer) and bit 1 (polarity) are stored; its other bits read 0. Writes to addresses 6 and 7 change nothing, and reads there return 0.
- R3: Source request `src_req[8*k+b]` is gated by bit b of enable register k+1. The merged request is the OR of all gated requests, except that position 15 is not a source.
- R4: Bit 7 of enable register 2 (address 1, bit 7) is the master gate. While it is 0 the pad shows the inactive level, whatever the requests are.
- R5: Pin control bit 1 sets the polarity: 0 means active low and 1 means active high.
- R6: With pin control bit 7 at 0 (open-drain), the pad is driven low (`pin_oe`=1, `pin_do`=0) only when the line level is low. Otherwise it is released (`pin_oe`=0, `pin_do`=0).
- R7: With pin control bit 7 at 1 (push-pull), `pin_oe` is 1 and `pin_do` equals the line level.
- R8: The pad outputs change on the first clock edge after a change in a request or a register, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| src_req | input | 40 | Source interrupt requests, active high |
| pin_oe | output | 1 | Pad drive enable |
| pin_do | output | 1 | Pad drive value |

## Verification
A wrong enable bit, whether stuck or misplaced, shows up as a single source that fails to move the pad, or one that moves it when it should not. The sweep over each source position and each enable position exposes it on the clock edge after the stimulus. A wrong control register shows up in every sample of the four polarity and buffer combinations: it can drive the pad high in open-drain mode, release it in push-pull mode, or invert the asserted level. A register that is missing or doubled shows up as an output that changes before the expected edge or one edge too late.

// File: rtl/smi_group.sv
module smi_group #(
  parameter int NREG       = 5,
  parameter int RW         = 8,
  parameter int AW         = 3,
  parameter int MASTER_REG = 1,
  parameter int MASTER_BIT = 7,
  parameter int BUF_BIT    = 7,
  parameter int POL_BIT    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [RW-1:0]      wdata,
  output logic [RW-1:0]      rdata,
  input  logic [NREG*RW-1:0] src_req,
  output logic               pin_oe,
  output logic               pin_do
);
  localparam int NSRC     = NREG * RW;
  localparam int CTL_ADDR = NREG;
  localparam int GATE_POS = MASTER_REG * RW + MASTER_BIT;

  logic [NREG-1:0][RW-1:0] en_q;
  logic                    push_pull_q;
  logic                    act_high_q;

  for (genvar k = 0; k < NREG; k++) begin : g_en
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) en_q[k] <= '0;
      else if (wr_en && addr == AW'(k)) en_q[k] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      push_pull_q <= 1'b0;
      act_high_q  <= 1'b0;
    end else if (wr_en && addr == AW'(CTL_ADDR)) begin
      push_pull_q <= wdata[BUF_BIT];
      act_high_q  <= wdata[POL_BIT];
    end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NREG; k++)
      if (addr == AW'(k)) rdata = en_q[k];
    if (addr == AW'(CTL_ADDR)) begin
      rdata[BUF_BIT] = push_pull_q;
      rdata[POL_BIT] = act_high_q;
    end
  end

  logic [NSRC-1:0] src_mask;
  always_comb begin
    src_mask = en_q;
    src_mask[GATE_POS] = 1'b0;
  end

  wire merged = |(src_req & src_mask) & en_q[MASTER_REG][MASTER_BIT];
  wire level  = act_high_q ? merged : ~merged;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_oe <= 1'b0;
      pin_do <= 1'b0;
    end else begin
      pin_oe <= push_pull_q | ~level;
      pin_do <= push_pull_q & level;
    end
endmodule

module smi_group_chk #(
  parameter int NSRC = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] src_mask,
  input logic            gate,
  input logic            push_pull_q,
  input logic            act_high_q,
  input logic            pin_oe,
  input logic            pin_do
);
  wire pad = pin_oe ? pin_do : 1'b1;

  a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(push_pull_q) |-> !pin_do);

  a_r7_pp_always_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $past(push_pull_q) |-> pin_oe);

  a_r4_gate_closed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate) |-> (pad == $past(!act_high_q)));

  a_r3_request_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate) && $past(|(src_req & src_mask))) |-> (pad == $past(act_high_q)));

  a_r3_no_request_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_req & src_mask) == '0) |-> (pad == $past(!act_high_q)));
endmodule

bind smi_group smi_group_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_mask(src_mask),
  .gate(en_q[MASTER_REG][MASTER_BIT]), .push_pull_q(push_pull_q),
  .act_high_q(act_high_q), .pin_oe(pin_oe), .pin_do(pin_do));

// File: tb/smi_group_test.sv
module smi_group_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [39:0] src_req = 0;
  logic        pin_oe, pin_do;

  int checks = 0, fails = 0;
  logic [39:0] en_m = 0;
  logic        pp_m = 0, pol_m = 0;

  always #4 clk = ~clk;

  smi_group uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_req(src_req), .pin_oe(pin_oe), .pin_do(pin_do));

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    if (a < 5) en_m[a*8 +: 8] = d;
    else if (a == 5) begin pp_m = d[7]; pol_m = d[1]; end
  endtask

  function automatic logic [1:0] expect_pin(logic [39:0] s);
    logic [39:0] m;
    logic act, lvl;
    m = en_m; m[15] = 1'b0;
    act = (|(s & m)) & en_m[15];
    lvl = pol_m ? act : ~act;
    return pp_m ? {1'b1, lvl} : {~lvl, 1'b0};
  endfunction

  task automatic apply(string req, logic [39:0] s);
    src_req = s;
    @(posedge clk); @(negedge clk);
    chk(req, {6'b0, pin_oe, pin_do}, {6'b0, expect_pin(s)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pad", {6'b0, pin_oe, pin_do}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      addr = 3'(a); #1;
      chk("R1 reg", rdata, 8'h00);
    end
    chk("R1 pad after reset", {6'b0, pin_oe, pin_do}, 8'h00);

    for (int a = 0; a < 5; a++) begin
      wr(3'(a), 8'(8'h35 + a * 8'h1B));
      addr = 3'(a); #1;
      chk("R2 readback", rdata, 8'(8'h35 + a * 8'h1B));
    end
    wr(3'd5, 8'hFF);
    addr = 3'd5; #1;
    chk("R2 ctl unused bits", rdata, 8'h82);
    wr(3'd6, 8'hAA);
    wr(3'd7, 8'h55);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R2 no alias", rdata, a < 5 ? en_m[a*8 +: 8] : (a == 5 ? 8'h82 : 8'h00));
    end
    wr(3'd5, 8'h00);

    for (int mode = 0; mode < 4; mode++) begin
      wr(3'd5, {mode[1], 5'b0, mode[0], 1'b0});
      for (int a = 0; a < 5; a++) wr(3'(a), 8'hFF);
      for (int i = 0; i < 40; i++) apply("R3 single source", 40'd1 << i);
      src_req = '1;
      for (int a = 0; a < 5; a++) wr(3'(a), a == 1 ? 8'h80 : 8'h00);
      for (int i = 0; i < 40; i++) begin
        if (i == 15) continue;
        wr(3'(i / 8), (i / 8 == 1 ? 8'h80 : 8'h00) | (8'd1 << (i % 8)));
        apply("R3 single enable", '1);
        wr(3'(i / 8), i / 8 == 1 ? 8'h80 : 8'h00);
      end
      wr(3'd1, 8'h7F);
      for (int a = 0; a < 5; a++) if (a != 1) wr(3'(a), 8'hFF);
      apply("R4 gate closed", '1);
      apply("R4 gate closed idle", '0);
      wr(3'd1, 8'hFF);
      apply("R5 R6 R7 active", 40'h00_0000_0100);
      apply("R5 R6 R7 idle", '0);
    end

    wr(3'd5, 8'h00);
    for (int a = 0; a < 5; a++) wr(3'(a), 8'hFF);
    apply("R8 settle", '0);
    src_req = 40'h1;
    #1;
    chk("R8 no early change", {6'b0, pin_oe, pin_do}, 8'h00);
    @(posedge clk); #1;
    chk("R8 one edge", {6'b0, pin_oe, pin_do}, 8'h02);
    @(negedge clk);
    addr = 3'd0; wdata = 8'h00; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
    chk("R8 enable write not yet seen", {6'b0, pin_oe, pin_do}, 8'h02);
    @(posedge clk); #1;
    chk("R8 enable write seen", {6'b0, pin_oe, pin_do}, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule